// File: doc/BRIEF.md
# Performance Event Counter Bank

This block keeps four running event counters for a processor core. Each time the core pulses its update strobe, it presents three step quantities: the clock cycles that elapsed, the load/store operations that completed, and the floating-point operations that completed. Each counter has a select code in one of two mode registers. The code decides which quantity, if any, the counter adds on that strobe. The counters are numbered 0 to 3.

Software uses a plain register port to load and read the counters and the mode registers. A write in the same cycle as an update wins over the increment. An interrupt request is raised when an enabled counter has its top bit set after an update. Counter 0 has its own enable, and counters 1 to 3 share a second enable. The request stays high until the exception controller acknowledges it.

Register map (`reg_addr`): 0 to 3 are counters 0 to 3. 4 is mode register A: bits [3:0] select for counter 0, bits [7:4] select for counter 1, bit 8 enables the counter-0 interrupt, bit 9 enables the shared interrupt for counters 1 to 3. 5 is mode register B: bits [3:0] select for counter 2, bits [7:4] select for counter 3. Addresses 6 and 7 read zero and ignore writes. Bit positions are those for the default select width of 4.

Top module: `pmc_unit`

## Requirements
- R1: After reset, all four counters, both mode registers and `irq_req` read zero.
- R2: Select code 0 leaves a counter unchanged on an update. So does any code that is not defined for that counter (for example 2, 7 or 15).
- R3: Select code 1 adds `step_cycles` to the counter on an update. This holds for all four counters.
- R4: Select code 11 adds `step_ldst` on counter 1 and `step_fp` on counter 2. On counters 0 and 3, code 11 leaves the counter unchanged.
- R5: Counters wrap modulo 2^32. For example, 0xFFFFFFFE plus 5 gives 0x00000003.
- R6: A register write to a counter in the same cycle as an update loads the written value, and no increment is applied to that counter. The other counters still update.
- R7: `irq_req` rises on the clock edge after an update, and only when the counter-0 enable (mode A bit 8) is on and bit 31 of counter 0 is set.
- R8: `irq_req` also rises on the clock edge after an update when the shared enable (mode A bit 9) is on and bit 31 of counter 1, 2 or 3 is set. The shared enable does not cover counter 0, and the counter-0 enable does not cover counters 1 to 3.
- R9: `irq_req` stays high until `irq_ack` is sampled high, and it clears on that edge. If a new set condition arrives on the same edge, the set wins.
- R10: Mode register A reads back only its 10 implemented bits, and mode register B reads back only its 8. All other bits, and addresses 6 and 7, read zero.
- R11: With `step_valid` low, the counters hold whatever the step inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_valid | input | 1 | Update strobe |
| step_cycles | input | 8 | Cycles elapsed in this step |
| step_ldst | input | 8 | Load/store operations completed in this step |
| step_fp | input | 8 | Floating-point operations completed in this step |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_ack | input | 1 | Acknowledge from the exception controller |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
Counter values and mode writes can be seen on `reg_rdata` just after the clock edge that samples the strobe or the write, because the read path is combinational. The interrupt request is due one edge later than the counter change that caused it. It clears on the edge that samples the acknowledge. The bench drives stimulus just after an edge, moves exactly one edge per step, and samples 1 ns after that edge. For the interrupt it checks both the edge where the request must still be low and the following edge where it must be high.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int unsigned NUM_CNT  = 4;
   localparam int unsigned ADDR_W   = 3;
   localparam int unsigned CODE_CYC = 1;
   localparam int unsigned CODE_AUX = 11;
   localparam logic [ADDR_W-1:0] ADR_MODE_A = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_MODE_B = 3'd5;

   // Which auxiliary quantity a counter may take under CODE_AUX
   typedef enum logic [1:0] {
      AUX_NONE = 2'd0,
      AUX_LDST = 2'd1,
      AUX_FP   = 2'd2
   } aux_src_e;

   function automatic aux_src_e aux_of(input int unsigned idx);
      case (idx)
         1:       return AUX_LDST;
         2:       return AUX_FP;
         default: return AUX_NONE;
      endcase
   endfunction
endpackage

// File: rtl/pmc_event_sel.sv
module pmc_event_sel
   import pmc_pkg::*;
#(
   parameter int unsigned IDX    = 0,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned STEP_W = 8,
   parameter int unsigned CNT_W  = 32
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [STEP_W-1:0] cycles,
   input  logic [STEP_W-1:0] ldst,
   input  logic [STEP_W-1:0] fp,
   output logic [CNT_W-1:0]  inc
);
   localparam aux_src_e AUX = aux_of(IDX);
   localparam int unsigned PAD = CNT_W - STEP_W;

   logic [STEP_W-1:0] aux_q;

   generate
      if (AUX == AUX_LDST) begin : g_ldst
         assign aux_q = ldst;
      end else if (AUX == AUX_FP) begin : g_fp
         assign aux_q = fp;
      end else begin : g_none
         assign aux_q = '0;
      end
   endgenerate

   always_comb begin
      inc = '0;
      if (sel == SEL_W'(CODE_CYC)) begin
         inc = {{PAD{1'b0}}, cycles};
      end else if ((sel == SEL_W'(CODE_AUX)) && (AUX != AUX_NONE)) begin
         inc = {{PAD{1'b0}}, aux_q};
      end
   end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             upd,
   input  logic [CNT_W-1:0] inc,
   output logic [CNT_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_data;
      end else if (upd) begin
         q <= q + inc;
      end
   end
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq #(
   parameter int unsigned NUM = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd_done,
   input  logic           en_own,
   input  logic           en_shared,
   input  logic [NUM-1:0] msb,
   input  logic           ack,
   output logic           req
);
   logic [NUM-1:0] armed;
   logic           hit;

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_arm
         if (i == 0) begin : g_own
            assign armed[i] = en_own & msb[i];
         end else begin : g_sh
            assign armed[i] = en_shared & msb[i];
         end
      end
   endgenerate

   assign hit = upd_done & (|armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else if (hit) begin
         req <= 1'b1;
      end else if (ack) begin
         req <= 1'b0;
      end
   end
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
   import pmc_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned STEP_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_valid,
   input  logic [STEP_W-1:0]    step_cycles,
   input  logic [STEP_W-1:0]    step_ldst,
   input  logic [STEP_W-1:0]    step_fp,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [CNT_W-1:0]     reg_wdata,
   output logic [CNT_W-1:0]     reg_rdata,
   input  logic                 irq_ack,
   output logic                 irq_req
);
   localparam int unsigned MODE_A_W = 2 * SEL_W + 2;
   localparam int unsigned MODE_B_W = 2 * SEL_W;
   localparam int unsigned BIT_OWN  = 2 * SEL_W;
   localparam int unsigned BIT_SH   = 2 * SEL_W + 1;

   generate
      if (SEL_W < 4) begin : g_bad_sel
         $error("SEL_W must hold select code 11");
      end
      if (CNT_W < STEP_W) begin : g_bad_step
         $error("CNT_W must be at least STEP_W");
      end
      if (CNT_W < MODE_A_W) begin : g_bad_bus
         $error("CNT_W too narrow for mode register A");
      end
   endgenerate

   logic [MODE_A_W-1:0]  mode_a_q;
   logic [MODE_B_W-1:0]  mode_b_q;
   logic [CNT_W-1:0]     cnt_q   [NUM_CNT];
   logic [CNT_W-1:0]     cnt_inc [NUM_CNT];
   logic [SEL_W-1:0]     sel     [NUM_CNT];
   logic [NUM_CNT-1:0]   cnt_msb;
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;
   logic                 upd_done_q;

   // Mode registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_a_q <= '0;
         mode_b_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADR_MODE_A) mode_a_q <= reg_wdata[MODE_A_W-1:0];
         if (reg_addr == ADR_MODE_B) mode_b_q <= reg_wdata[MODE_B_W-1:0];
      end
   end

   // Marks the cycle after an update so the request sees the new counts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_done_q <= 1'b0;
      else        upd_done_q <= step_valid;
   end

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         if (i < 2) begin : g_sel_a
            assign sel[i] = mode_a_q[i*SEL_W +: SEL_W];
         end else begin : g_sel_b
            assign sel[i] = mode_b_q[(i-2)*SEL_W +: SEL_W];
         end

         pmc_event_sel #(
            .IDX(i), .SEL_W(SEL_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
         ) u_sel (
            .sel(sel[i]), .cycles(step_cycles), .ldst(step_ldst),
            .fp(step_fp), .inc(cnt_inc[i])
         );

         pmc_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_we && (reg_addr == ADDR_W'(i))),
            .wr_data(reg_wdata),
            .upd(step_valid), .inc(cnt_inc[i]), .q(cnt_q[i])
         );

         assign cnt_msb[i] = cnt_q[i][CNT_W-1];
         assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
      end
   endgenerate

   pmc_irq #(.NUM(NUM_CNT)) u_irq (
      .clk(clk), .rst_n(rst_n), .upd_done(upd_done_q),
      .en_own(mode_a_q[BIT_OWN]), .en_shared(mode_a_q[BIT_SH]),
      .msb(cnt_msb), .ack(irq_ack), .req(irq_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr < ADDR_W'(NUM_CNT)) begin
         reg_rdata = cnt_q[reg_addr[1:0]];
      end else if (reg_addr == ADR_MODE_A) begin
         reg_rdata = {{(CNT_W-MODE_A_W){1'b0}}, mode_a_q};
      end else if (reg_addr == ADR_MODE_B) begin
         reg_rdata = {{(CNT_W-MODE_B_W){1'b0}}, mode_b_q};
      end
   end
endmodule

// File: rtl/pmc_unit_chk.sv
module pmc_unit_chk #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned SEL_W = 4,
   parameter int unsigned NUM   = 4,
   parameter int unsigned AW    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 step_valid,
   input logic                 reg_we,
   input logic [AW-1:0]        reg_addr,
   input logic [CNT_W-1:0]     reg_wdata,
   input logic                 irq_ack,
   input logic                 irq_req,
   input logic [NUM*CNT_W-1:0] cnt_flat,
   input logic [SEL_W-1:0]     sel0
);
   logic prev_step;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_step <= 1'b0;
      else        prev_step <= step_valid;
   end

   function automatic logic [CNT_W-1:0] cnt_at(input logic [AW-1:0] a);
      return cnt_flat[a[1:0]*CNT_W +: CNT_W];
   endfunction

   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_valid && !reg_we) |=> $stable(cnt_flat));

   assert_sel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && sel0 == '0 && !(reg_we && reg_addr == '0))
      |=> $stable(cnt_flat[CNT_W-1:0]));

   assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr < AW'(NUM))
      |=> cnt_at($past(reg_addr)) == $past(reg_wdata));

   assert_rise_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> prev_step == 1'b0 && $past(prev_step));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> irq_req);

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !prev_step) |=> !irq_req);
endmodule

bind pmc_unit pmc_unit_chk #(
   .CNT_W(CNT_W), .SEL_W(SEL_W), .NUM(pmc_pkg::NUM_CNT), .AW(pmc_pkg::ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_ack(irq_ack),
   .irq_req(irq_req), .cnt_flat(cnt_flat), .sel0(mode_a_q[SEL_W-1:0])
);

// File: tb/sim_pmc_unit.sv
`timescale 1ns/1ps
module sim_pmc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_valid = 1'b0;
   logic [7:0]  step_cycles = '0, step_ldst = '0, step_fp = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_ack = 1'b0;
   logic        irq_req;

   int nvec = 0;
   int nfail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pmc_unit u0 (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid),
      .step_cycles(step_cycles), .step_ldst(step_ldst), .step_fp(step_fp),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.5;
      check(tag, reg_rdata, exp);
   endtask

   task automatic step(input logic [7:0] c, input logic [7:0] l, input logic [7:0] f);
      step_valid = 1'b1; step_cycles = c; step_ldst = l; step_fp = f;
      tick();
      step_valid = 1'b0;
   endtask

   task automatic load_all(input logic [31:0] v);
      for (int i = 0; i < 4; i++) wr(3'(i), v);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 6; i++) rd_check("R1 reset reg", 3'(i), 32'h0);
      check("R1 reset irq", {31'b0, irq_req}, 32'h0);
   endtask

   task automatic t_cycles();
      wr(3'd4, 32'h11); wr(3'd5, 32'h11);
      step(8'd5, 8'd3, 8'd2);
      for (int i = 0; i < 4; i++) rd_check("R3 cycles first", 3'(i), 32'd5);
      step(8'd7, 8'd1, 8'd1);
      for (int i = 0; i < 4; i++) rd_check("R3 cycles accum", 3'(i), 32'd12);
   endtask

   task automatic t_aux();
      load_all(32'h0);
      wr(3'd4, 32'hBB); wr(3'd5, 32'hBB);
      step(8'd5, 8'd3, 8'd2);
      rd_check("R4 code11 cnt0 holds", 3'd0, 32'd0);
      rd_check("R4 code11 cnt1 ldst", 3'd1, 32'd3);
      rd_check("R4 code11 cnt2 fp", 3'd2, 32'd2);
      rd_check("R4 code11 cnt3 holds", 3'd3, 32'd0);
   endtask

   task automatic t_hold();
      load_all(32'd100);
      wr(3'd4, 32'h20); wr(3'd5, 32'h7F);
      step(8'd9, 8'd9, 8'd9);
      for (int i = 0; i < 4; i++) rd_check("R2 code0/undefined holds", 3'(i), 32'd100);
      wr(3'd4, 32'h11); wr(3'd5, 32'h11);
      step_cycles = 8'd50; step_ldst = 8'd50; step_fp = 8'd50;
      tick(); tick();
      for (int i = 0; i < 4; i++) rd_check("R11 strobe low holds", 3'(i), 32'd100);
   endtask

   task automatic t_wrap();
      wr(3'd4, 32'h11);
      wr(3'd0, 32'hFFFF_FFFE);
      step(8'd5, 8'd0, 8'd0);
      rd_check("R5 wrap", 3'd0, 32'h0000_0003);
   endtask

   task automatic t_prio();
      load_all(32'd10);
      wr(3'd4, 32'h11); wr(3'd5, 32'h11);
      step_valid = 1'b1; step_cycles = 8'd4;
      reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h55;
      tick();
      step_valid = 1'b0; reg_we = 1'b0;
      rd_check("R6 write wins", 3'd2, 32'h55);
      rd_check("R6 other counter updates", 3'd1, 32'd14);
   endtask

   task automatic t_irq();
      load_all(32'h0);
      wr(3'd4, 32'h111); wr(3'd5, 32'h0);
      wr(3'd0, 32'h7FFF_FFFF);
      step(8'd1, 8'd0, 8'd0);
      check("R7 irq not yet", {31'b0, irq_req}, 32'h0);
      tick();
      check("R7 irq raised", {31'b0, irq_req}, 32'h1);
      tick(); tick();
      check("R9 irq sticky", {31'b0, irq_req}, 32'h1);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      check("R9 ack clears", {31'b0, irq_req}, 32'h0);
      // shared enable only: counter 0 high must not raise
      wr(3'd4, 32'h200);
      step(8'd1, 8'd0, 8'd0); tick();
      check("R8 shared ignores cnt0", {31'b0, irq_req}, 32'h0);
      wr(3'd3, 32'h8000_0000);
      step(8'd1, 8'd0, 8'd0); tick();
      check("R8 shared cnt3", {31'b0, irq_req}, 32'h1);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      // own enable only: counter 3 high must not raise
      wr(3'd0, 32'h0);
      wr(3'd4, 32'h100);
      step(8'd1, 8'd0, 8'd0); tick();
      check("R8 own ignores cnt3", {31'b0, irq_req}, 32'h0);
      // set wins over ack on the same edge
      wr(3'd4, 32'h200);
      step(8'd1, 8'd0, 8'd0); tick();
      step(8'd1, 8'd0, 8'd0);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      check("R9 set wins over ack", {31'b0, irq_req}, 32'h1);
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      check("R9 ack after set", {31'b0, irq_req}, 32'h0);
   endtask

   task automatic t_readback();
      wr(3'd4, 32'hFFFF_FFFF);
      rd_check("R10 mode A mask", 3'd4, 32'h0000_03FF);
      wr(3'd5, 32'hFFFF_FFFF);
      rd_check("R10 mode B mask", 3'd5, 32'h0000_00FF);
      wr(3'd6, 32'hFFFF_FFFF);
      rd_check("R10 addr 6 zero", 3'd6, 32'h0);
      rd_check("R10 addr 7 zero", 3'd7, 32'h0);
      wr(3'd4, 32'h0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         nvec++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_cycles();
      t_aux();
      t_hold();
      t_wrap();
      t_prio();
      t_irq();
      t_readback();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule